// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block produces up to four pulse-width-modulated outputs, all timed by one prescaler and one up-counter. Every channel therefore runs at the same period and differs only in its compare value, its mode selection, its enables and its polarities. Each channel has a main output and, if the `HAS_COMP` parameter is set, a complementary output.

Software reaches the block through a simple register bus. Writes are single cycle and reads are combinational. Period and compare values can be held in preload copies and moved into the active copies together on an update event. An update event happens when the counter wraps, or when software writes the force-update bit. Enable bits that the build does not implement read back as zero, so software can find out how many channels and complementary outputs exist by writing all ones and reading the value back.

The counter is driven by a two-state machine. In `ST_IDLE` the counter is stopped. In `ST_COUNT` the prescaler and the counter advance. The transition START goes from `ST_IDLE` to `ST_COUNT` and is taken when the run bit is 1. The transition HALT goes from `ST_COUNT` to `ST_IDLE` and is taken when the run bit is 0.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset every register is zero, the counter is zero, and every output is low.
- R2: In `ST_COUNT` the counter advances once every prescaler+1 clocks. CTRL bit0 is the run bit. The state machine follows the run bit one clock later, so counting begins on the second clock after the run bit is written.
- R3: On the prescaler tick where the counter is at or above the active period, the counter wraps to 0 and raises an update event. A period value of N gives N+1 counts per cycle.
- R4: If CTRL bit1 (period preload) is 1, a period write changes only the preload copy, and the active period takes that value at the next update event. If CTRL bit1 is 0, the written period becomes active on the next clock.
- R5: Writing 1 to bit0 of EVENT forces an update event. The event copies all preload values into the active copies and clears both the counter and the prescaler, even while the counter is stopped.
- R6: Bit3 of a channel's mode byte is the compare preload bit. If it is 1, a compare write waits for the next update event. If it is 0, the write is active on the next clock.
- R7: Mode byte bits[6:4] equal to 3'b110 select PWM mode 1. In this mode the channel's reference level is active while count < active compare. A compare value of 0 gives 0% duty and a compare value above the period gives 100% duty. Any other mode code makes the reference level inactive.
- R8: For each channel, bit ch*4+1 inverts the main output and bit ch*4+3 inverts the complementary output. The complementary output starts from the inverse of the reference level.
- R9: When an output's enable bit is 0, the output drives its polarity bit, which is its inactive level.
- R10: In CHEN, each channel uses bits ch*4+0 (main enable), +1 (main polarity), +2 (complementary enable) and +3 (complementary polarity). Groups for channels at or above `NUM_CH`, and complementary bits when `HAS_COMP`=0, read back as 0, and the outputs that such bits would control stay low.
- R11: Clearing the run bit freezes the counter at its current value.
- R12: Register addresses are: 0 CTRL, 1 EVENT (reads 0), 2 PSC, 3 PERIOD, 4 MODE for channels 0/1 (low byte = channel 0), 5 MODE for channels 2/3, 6 CHEN, and 8..11 compare values for channels 0..3. PERIOD and compare addresses read back the preload copies, and unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| pwm_o | output | 4 | Main channel outputs |
| pwm_n_o | output | 4 | Complementary channel outputs |
| count_o | output | CNT_W | Current counter value |

## Verification
A stuck or mistimed prescaler shows up on `count_o` within one prescaler period, and a missed wrap shows up as a count above the period one tick later. A wrong preload or update transfer leaves the active period or compare out of step with the model. That becomes visible at the next wrap, as an edge of `pwm_o` in the wrong cycle. Errors in polarity, enable or masking show up in the same cycle on `pwm_o`, `pwm_n_o` or on a CHEN read-back. A model that runs in lockstep therefore catches each of these faults within one counter period.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    localparam int MAX_CH = 4;
    localparam int GRP_W  = 4;
    localparam int MODE_W = 8;
    localparam int CHEN_W = MAX_CH * GRP_W;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVENT   = 4'd1;
    localparam logic [ADDR_W-1:0] A_PSC     = 4'd2;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_MODE_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_CHEN    = 4'd6;
    localparam logic [ADDR_W-1:0] A_CMP0    = 4'd8;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_ARPE = 1;
    localparam int EVT_UPD   = 0;

    localparam int GRP_EN   = 0;
    localparam int GRP_POL  = 1;
    localparam int GRP_NEN  = 2;
    localparam int GRP_NPOL = 3;

    localparam int          MODE_PRE  = 3;
    localparam logic [2:0]  MODE_PWM1 = 3'b110;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_t;

    // Implemented CHEN bits for a build with n channels.
    function automatic logic [CHEN_W-1:0] impl_mask(input int n, input int comp);
        logic [CHEN_W-1:0] m;
        m = '0;
        for (int c = 0; c < MAX_CH; c++) begin
            if (c < n) begin
                m[c*GRP_W + GRP_EN]  = 1'b1;
                m[c*GRP_W + GRP_POL] = 1'b1;
                if (comp != 0) begin
                    m[c*GRP_W + GRP_NEN]  = 1'b1;
                    m[c*GRP_W + GRP_NPOL] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int HAS_COMP = 1,
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 16,
    parameter int DATA_W   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic                              wrap_i,
    output logic                              force_o,
    output logic                              run_o,
    output logic [PSC_W-1:0]                  psc_o,
    output logic [CNT_W-1:0]                  period_o,
    output logic [MAX_CH-1:0][CNT_W-1:0]      cmp_o,
    output logic [MAX_CH-1:0][2:0]            sel_o,
    output logic [CHEN_W-1:0]                 chen_o
);

    localparam logic [CHEN_W-1:0] IMPL_MASK = impl_mask(NUM_CH, HAS_COMP);

    logic [1:0]                         ctrl_q;
    logic [PSC_W-1:0]                   psc_q;
    logic [CNT_W-1:0]                   per_pre_q, per_act_q;
    logic [MAX_CH-1:0][MODE_W-1:0]      mode_q;
    logic [CHEN_W-1:0]                  chen_q;
    logic [MAX_CH-1:0][CNT_W-1:0]       cmp_pre_q, cmp_act_q;

    logic wr, upd;

    assign wr      = bus_sel && bus_wr;
    assign force_o = wr && (bus_addr == A_EVENT) && bus_wdata[EVT_UPD];
    assign upd     = force_o || wrap_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            psc_q     <= '0;
            per_pre_q <= '0;
            per_act_q <= '0;
            mode_q    <= '0;
            chen_q    <= '0;
            cmp_pre_q <= '0;
            cmp_act_q <= '0;
        end else begin
            if (wr && bus_addr == A_CTRL)    ctrl_q    <= bus_wdata[1:0];
            if (wr && bus_addr == A_PSC)     psc_q     <= bus_wdata[PSC_W-1:0];
            if (wr && bus_addr == A_PERIOD)  per_pre_q <= bus_wdata[CNT_W-1:0];
            if (wr && bus_addr == A_CHEN)    chen_q    <= bus_wdata[CHEN_W-1:0] & IMPL_MASK;
            if (wr && bus_addr == A_MODE_LO) begin
                mode_q[0] <= bus_wdata[MODE_W-1:0];
                mode_q[1] <= bus_wdata[2*MODE_W-1:MODE_W];
            end
            if (wr && bus_addr == A_MODE_HI) begin
                mode_q[2] <= bus_wdata[MODE_W-1:0];
                mode_q[3] <= bus_wdata[2*MODE_W-1:MODE_W];
            end

            // Active period: direct write without preload, else update copy.
            if (wr && bus_addr == A_PERIOD && !ctrl_q[CTRL_ARPE])
                per_act_q <= bus_wdata[CNT_W-1:0];
            else if (upd)
                per_act_q <= per_pre_q;

            for (int i = 0; i < MAX_CH; i++) begin
                if (wr && bus_addr == A_CMP0 + ADDR_W'(i)) begin
                    cmp_pre_q[i] <= bus_wdata[CNT_W-1:0];
                end
                if (wr && bus_addr == A_CMP0 + ADDR_W'(i) && !mode_q[i][MODE_PRE])
                    cmp_act_q[i] <= bus_wdata[CNT_W-1:0];
                else if (upd)
                    cmp_act_q[i] <= cmp_pre_q[i];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:    bus_rdata = DATA_W'(ctrl_q);
            A_PSC:     bus_rdata = DATA_W'(psc_q);
            A_PERIOD:  bus_rdata = DATA_W'(per_pre_q);
            A_MODE_LO: bus_rdata = DATA_W'({mode_q[1], mode_q[0]});
            A_MODE_HI: bus_rdata = DATA_W'({mode_q[3], mode_q[2]});
            A_CHEN:    bus_rdata = DATA_W'(chen_q);
            default: begin
                if (bus_addr[3:2] == 2'b10)
                    bus_rdata = DATA_W'(cmp_pre_q[bus_addr[1:0]]);
            end
        endcase
    end

    assign run_o    = ctrl_q[CTRL_RUN];
    assign psc_o    = psc_q;
    assign period_o = per_act_q;
    assign cmp_o    = cmp_act_q;
    assign chen_o   = chen_q;

    generate
        for (genvar g = 0; g < MAX_CH; g++) begin : g_sel
            assign sel_o[g] = mode_q[g][6:4];
        end
    endgenerate

    // R4: with preload on, the active period moves only on an update event.
    p_period_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_ARPE] && !upd) |=> $stable(per_act_q));

    // R10: bits of channels that are not built never read back as 1.
    p_chen_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_CHEN) |->
        ((bus_rdata[CHEN_W-1:0] & ~IMPL_MASK) == '0));

endmodule

// File: rtl/mcpwm_counter.sv
module mcpwm_counter
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             force_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    cnt_state_t       state_q, state_d;
    logic [PSC_W-1:0] pc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    // Next-state: START (idle->count) and HALT (count->idle).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_i)  state_d = ST_COUNT;
            ST_COUNT: if (!run_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode of the state machine.
    always_comb begin
        tick   = (state_q == ST_COUNT) && (pc_q >= psc_i);
        wrap_o = tick && (cnt_q >= period_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (force_i) begin
            pc_q  <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_COUNT) begin
            pc_q <= tick ? '0 : pc_q + PSC_W'(1);
            if (tick) cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R3: a wrapping tick takes the counter to zero.
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !force_i) |=> (cnt_q == '0));

    // R5: a forced update clears the counter and the prescaler.
    p_force_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (cnt_q == '0 && pc_q == '0));

    // R11: a stopped counter holds its value.
    p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !force_i) |=> $stable(cnt_q));

endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
    import mcpwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int HAS_COMP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [2:0]       sel_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic             main_o,
    output logic             comp_o
);

    logic ref_lvl;

    assign ref_lvl = (sel_i == MODE_PWM1) && (cnt_i < cmp_i);
    assign main_o  = grp_i[GRP_EN] ? (ref_lvl ^ grp_i[GRP_POL]) : grp_i[GRP_POL];

    generate
        if (HAS_COMP != 0) begin : g_comp
            assign comp_o = grp_i[GRP_NEN] ? (~ref_lvl ^ grp_i[GRP_NPOL]) : grp_i[GRP_NPOL];

            // R8: both enabled -> the two outputs are opposite before polarity.
            p_comp_opposite_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_i[GRP_EN] && grp_i[GRP_NEN]) |->
                ((main_o ^ grp_i[GRP_POL]) != (comp_o ^ grp_i[GRP_NPOL])));
        end else begin : g_nocomp
            assign comp_o = 1'b0;
        end
    endgenerate

    // R7: compare of zero never drives the active level.
    p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i[GRP_EN] && cmp_i == '0) |-> (main_o == grp_i[GRP_POL]));

endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
    import mcpwm_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int HAS_COMP = 1,
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 16,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [3:0]        pwm_o,
    output logic [3:0]        pwm_n_o,
    output logic [CNT_W-1:0]  count_o
);

    logic                          force_w, wrap_w, run_w;
    logic [PSC_W-1:0]              psc_w;
    logic [CNT_W-1:0]              period_w, cnt_w;
    logic [MAX_CH-1:0][CNT_W-1:0]  cmp_w;
    logic [MAX_CH-1:0][2:0]        sel_w;
    logic [CHEN_W-1:0]             chen_w;

    mcpwm_regs #(
        .NUM_CH(NUM_CH), .HAS_COMP(HAS_COMP), .CNT_W(CNT_W),
        .PSC_W(PSC_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap_i(wrap_w), .force_o(force_w), .run_o(run_w),
        .psc_o(psc_w), .period_o(period_w), .cmp_o(cmp_w),
        .sel_o(sel_w), .chen_o(chen_w)
    );

    mcpwm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .psc_i(psc_w),
        .period_i(period_w), .force_i(force_w),
        .cnt_o(cnt_w), .wrap_o(wrap_w)
    );

    // Unbuilt channels see a masked-off CHEN group and so stay low.
    generate
        for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
            mcpwm_channel #(.CNT_W(CNT_W), .HAS_COMP(HAS_COMP)) u_ch (
                .clk(clk), .rst_n(rst_n),
                .cnt_i(cnt_w), .cmp_i(cmp_w[c]), .sel_i(sel_w[c]),
                .grp_i(chen_w[c*GRP_W +: GRP_W]),
                .main_o(pwm_o[c]), .comp_o(pwm_n_o[c])
            );
        end
    endgenerate

    assign count_o = cnt_w;

endmodule

// File: tb/mcpwm_timer_tb.sv
module mcpwm_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 3;
    localparam int HAS_COMP   = 1;
    localparam int CNT_W      = 16;
    localparam int PSC_W      = 16;
    localparam int DATA_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [3:0]        pwm_o, pwm_n_o;
    logic [CNT_W-1:0]  count_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcpwm_timer #(
        .NUM_CH(NUM_CH), .HAS_COMP(HAS_COMP), .CNT_W(CNT_W),
        .PSC_W(PSC_W), .DATA_W(DATA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .count_o(count_o)
    );

    // Reference model state
    logic        m_run, m_arpe, m_running;
    logic [15:0] m_psc, m_pc, m_cnt, m_per_pre, m_per_act, m_chen;
    logic [7:0]  m_mode [4];
    logic [15:0] m_cmp_pre [4];
    logic [15:0] m_cmp_act [4];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [15:0] built_bits();
        logic [15:0] m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[c*4]   = 1'b1;
            m[c*4+1] = 1'b1;
            if (HAS_COMP != 0) begin
                m[c*4+2] = 1'b1;
                m[c*4+3] = 1'b1;
            end
        end
        return m;
    endfunction

    task automatic m_reset();
        m_run = 0; m_arpe = 0; m_running = 0;
        m_psc = 0; m_pc = 0; m_cnt = 0; m_per_pre = 0; m_per_act = 0; m_chen = 0;
        for (int i = 0; i < 4; i++) begin
            m_mode[i] = 0; m_cmp_pre[i] = 0; m_cmp_act[i] = 0;
        end
    endtask

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {14'd0, m_arpe, m_run};
            4'd2: return m_psc;
            4'd3: return m_per_pre;
            4'd4: return {m_mode[1], m_mode[0]};
            4'd5: return {m_mode[3], m_mode[2]};
            4'd6: return m_chen;
            4'd8, 4'd9, 4'd10, 4'd11: return m_cmp_pre[a - 4'd8];
            default: return 16'd0;
        endcase
    endfunction

    task automatic m_step(input logic sel, input logic we, input logic [3:0] a, input logic [15:0] d);
        logic wr, frc, tick, wrp, upd;
        logic [15:0] n_pc, n_cnt, n_per;
        logic [15:0] n_cmp [4];
        wr   = sel && we;
        frc  = wr && (a == 4'd1) && d[0];
        tick = m_running && (m_pc >= m_psc);
        wrp  = tick && (m_cnt >= m_per_act);
        upd  = frc || wrp;
        n_pc  = frc ? 16'd0 : (m_running ? (tick ? 16'd0 : m_pc + 16'd1) : m_pc);
        n_cnt = frc ? 16'd0 : (tick ? (wrp ? 16'd0 : m_cnt + 16'd1) : m_cnt);
        n_per = m_per_act;
        if (wr && a == 4'd3 && !m_arpe) n_per = d;
        else if (upd)                   n_per = m_per_pre;
        for (int i = 0; i < 4; i++) begin
            n_cmp[i] = m_cmp_act[i];
            if (wr && a == 4'(8 + i) && !m_mode[i][3]) n_cmp[i] = d;
            else if (upd)                             n_cmp[i] = m_cmp_pre[i];
        end
        m_running = m_run;
        if (wr) begin
            case (a)
                4'd0: begin m_run = d[0]; m_arpe = d[1]; end
                4'd2: m_psc = d;
                4'd3: m_per_pre = d;
                4'd4: begin m_mode[0] = d[7:0]; m_mode[1] = d[15:8]; end
                4'd5: begin m_mode[2] = d[7:0]; m_mode[3] = d[15:8]; end
                4'd6: m_chen = d & built_bits();
                4'd8, 4'd9, 4'd10, 4'd11: m_cmp_pre[a - 4'd8] = d;
                default: ;
            endcase
        end
        m_pc = n_pc; m_cnt = n_cnt; m_per_act = n_per;
        for (int i = 0; i < 4; i++) m_cmp_act[i] = n_cmp[i];
    endtask

    function automatic logic [3:0] exp_main();
        logic [3:0] r;
        for (int c = 0; c < 4; c++) begin
            logic rl;
            rl = (m_mode[c][6:4] == 3'b110) && (m_cnt < m_cmp_act[c]);
            r[c] = m_chen[c*4] ? (rl ^ m_chen[c*4+1]) : m_chen[c*4+1];
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_comp();
        logic [3:0] r;
        for (int c = 0; c < 4; c++) begin
            logic rl;
            rl = (m_mode[c][6:4] == 3'b110) && (m_cnt < m_cmp_act[c]);
            r[c] = m_chen[c*4+2] ? (~rl ^ m_chen[c*4+3]) : m_chen[c*4+3];
            if (HAS_COMP == 0) r[c] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        check(tag, "count_o", 32'(count_o), 32'(m_cnt));
        check(tag, "pwm_o",   32'(pwm_o),   32'(exp_main()));
        check(tag, "pwm_n_o", 32'(pwm_n_o), 32'(exp_comp()));
    endtask

    // One bus cycle; entered and left just after a falling edge.
    task automatic cyc(input string otag, input string rtag, input logic sel, input logic we,
                       input logic [3:0] a, input logic [15:0] d);
        bus_sel = sel; bus_wr = we; bus_addr = a; bus_wdata = d;
        #1;
        if (sel && !we) check(rtag, "bus_rdata", 32'(bus_rdata), 32'(m_read(a)));
        @(posedge clk);
        m_step(sel, we, a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check_outputs(otag);
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [15:0] d);
        cyc(tag, tag, 1'b1, 1'b1, a, d);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, tag, 1'b0, 1'b0, 4'd0, 16'd0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check("R1", "count_o", 32'(count_o), 32'd0);
        check("R1", "pwm_o",   32'(pwm_o),   32'd0);
        check("R1", "pwm_n_o", 32'(pwm_n_o), 32'd0);
        @(negedge clk);
        for (int a = 0; a < 16; a++) cyc("R1", "R1", 1'b1, 1'b0, 4'(a), 16'd0);

        // R10: probe built enables
        wr("R10", 4'd6, 16'hFFFF);
        cyc("R10", "R10", 1'b1, 1'b0, 4'd6, 16'd0);
        check("R10", "probe value", 32'(bus_rdata), 32'h0FFF);
        wr("R10", 4'd6, 16'h0000);

        // R2: prescaler 2, period 5, channel 0 PWM1
        wr("R2", 4'd2, 16'd2);
        wr("R2", 4'd3, 16'd5);
        wr("R2", 4'd4, 16'h6060);
        wr("R2", 4'd8, 16'd3);
        wr("R2", 4'd6, 16'h0005);
        wr("R2", 4'd0, 16'h0001);
        idle("R2", 30);
        idle("R3", 20);

        // R7: duty extremes and non-PWM mode
        wr("R7", 4'd8, 16'd0);
        idle("R7", 20);
        wr("R7", 4'd8, 16'd9);
        idle("R7", 20);
        wr("R7", 4'd4, 16'h6020);
        idle("R7", 10);
        wr("R7", 4'd4, 16'h6060);

        // R8: polarity and complementary on channels 0 and 1
        wr("R8", 4'd9, 16'd2);
        wr("R8", 4'd6, 16'h00F7);
        idle("R8", 20);

        // R9: disabled outputs show polarity
        wr("R9", 4'd6, 16'h0A0A);
        idle("R9", 10);
        wr("R9", 4'd6, 16'h0055);

        // R4: period preload
        wr("R4", 4'd0, 16'h0003);
        wr("R4", 4'd3, 16'd2);
        cyc("R4", "R12", 1'b1, 1'b0, 4'd3, 16'd0);
        idle("R4", 30);
        wr("R4", 4'd0, 16'h0001);
        wr("R4", 4'd3, 16'd7);
        idle("R4", 10);

        // R6: compare preload on channel 0
        wr("R6", 4'd4, 16'h6068);
        wr("R6", 4'd8, 16'd5);
        idle("R6", 30);

        // R5: forced update
        wr("R5", 4'd8, 16'd1);
        wr("R5", 4'd1, 16'h0001);
        idle("R5", 5);
        wr("R0", 4'd0, 16'h0000);
        wr("R5", 4'd1, 16'h0001);

        // R11: stop freezes
        wr("R11", 4'd0, 16'h0001);
        idle("R11", 7);
        wr("R11", 4'd0, 16'h0000);
        idle("R11", 10);
        wr("R11", 4'd0, 16'h0001);

        // Mixed random traffic
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 70) begin
                logic [3:0] a;
                a = 4'($urandom_range(0, 15));
                cyc("R3", (a == 4'd6) ? "R10" : "R12", 1'b1, 1'b0, a, 16'd0);
            end else begin
                logic [3:0]  a;
                logic [15:0] d;
                int k;
                k = $urandom_range(0, 10);
                a = (k < 7) ? 4'(k) : 4'(k + 1);
                case (a)
                    4'd0: d = {14'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) < 8)};
                    4'd1: d = 16'($urandom_range(0, 1));
                    4'd2: d = 16'($urandom_range(0, 3));
                    4'd3: d = 16'($urandom_range(0, 12));
                    4'd4, 4'd5: begin
                        d = 16'($urandom);
                        if ($urandom_range(0, 4) != 0) d[6:4]   = 3'b110;
                        if ($urandom_range(0, 4) != 0) d[14:12] = 3'b110;
                    end
                    4'd6: d = 16'($urandom);
                    default: d = 16'($urandom_range(0, 15));
                endcase
                cyc("R7", "R8", 1'b1, 1'b1, a, d);
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule